// File: doc/BRIEF.md
# MDIO Management Serial Target

This block is the PHY-side end of a two-wire station management link. Every input bit is sampled on the rising edge of the management clock. The block decodes read and write frames bit by bit and keeps 32 sixteen-bit registers, which stand in for a PHY's register set.

A frame may start with a run of ones, but it does not have to. The block looks for a start code and then collects, in order:

- the opcode,
- a 5-bit PHY address, which is compared with a strap input,
- a 5-bit register address,
- two turnaround bits,
- sixteen data bits.

A write updates the addressed register once the last data bit has arrived. A read releases the line for the first turnaround bit, drives zero for the second, and then shifts the register contents out most significant bit first through an output value and an output enable. The enable is meant for an external tri-state pad. Register 1 carries a status flag in bit 6 that always reads as 1. It tells the station that frames without a preamble are accepted.

The decoder is a single state machine with these states:

- **HUNT**: waits for a start-code leader. It moves to SOF when it samples a 0 while armed. It is armed after a 1, after reset, and right after a completed frame.
- **SOF**: moves to OPC on a 1. A 0 sends it back to HUNT, disarmed.
- **OPC**: after two bits, moves to PHY on a valid opcode. Any other code returns it to HUNT.
- **PHY**: after five bits, moves to REG when the address matches the strap, and to HUNT when it does not.
- **REG**: after five bits, moves to TURN.
- **TURN**: after two bits, moves to RDATA for a read or WDATA for a write.
- **WDATA** and **RDATA**: return to HUNT, armed, after sixteen bits.

Top module: `mdio_target`

## Requirements
- R1: After reset the output enable is low, and every register reads 0x0000, except that register 1 reads 0x0040.
- R2: A write frame (start code 01, opcode 01, matching PHY address) stores its 16-bit data field in the addressed register once all 16 data bits have been sampled. A later read returns that value.
- R3: Frames with no preamble are accepted, for both reads and writes, when they follow an idle line.
- R4: Opcodes 00 and 11 are ignored: the output enable stays low and no register changes.
- R5: A frame whose PHY address differs from the strap is ignored: no register is written and the output enable stays low.
- R6: The address and data fields are taken most significant bit first. A register address of 5 (00101) and one of 20 (10100) select different registers.
- R7: In a read frame, the output enable is low during the first turnaround bit. During the second turnaround bit it is high and the line is driven to 0.
- R8: A read drives the 16 data bits most significant bit first in the 16 bit times after the turnaround. The output enable is low again in the bit time that follows the last data bit.
- R9: During a write frame the output enable never goes high.
- R10: Bit 6 of register 1 always reads as 1, whatever was written to it. The other bits of register 1 hold the written value.
- R11: A new frame with no preamble may follow the last data bit of the previous frame in the very next bit time. Both write-to-write and read-to-read sequences are decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all sampling and updates occur on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_in | input | 1 | Resolved level of the bidirectional management data line |
| phy_strap | input | 5 | PHY address this target answers to |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the external tri-state driver |

## Verification
The bench drives frames with a full 32-bit preamble, with no preamble after idle, and with no gap at all after a previous frame. This separates start-code hunting from plain preamble counting. Data values are asymmetric and register addresses are bit-mirrored, so a reversed or shifted field shows up in the read-back. Frames with opcodes 00 and 11, or with a PHY address one bit off the strap, are built so that their tails cannot form a false frame. Any write or line drive after such a frame can therefore come only from a decoding fault. The turnaround bits and the release after the last data bit are observed on the line itself, because that is where a drive conflict with the station would occur.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SOF,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TURN,
        ST_WDATA,
        ST_RDATA
    } mdio_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_target_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mdio_in,
    input  logic [ADDR_W-1:0]         phy_strap,
    output mdio_state_e               state,
    output logic [ADDR_W-1:0]         reg_addr,
    output logic                      wr_en,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      tx_turn,
    output logic                      tx_load,
    output logic                      tx_shift,
    output logic                      tx_drop
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    mdio_state_e         state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                armed_q, armed_d;
    logic                rd_q, rd_d;
    logic [DATA_W-1:0]   sh_q, sh_d;
    logic [ADDR_W-1:0]   ra_q, ra_d;

    // next-state decision, one bit per MDC edge
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        armed_d = armed_q;
        rd_d    = rd_q;
        sh_d    = sh_q;
        ra_d    = ra_q;
        unique case (state_q)
            ST_HUNT: begin
                armed_d = mdio_in;
                if (!mdio_in && armed_q) begin
                    state_d = ST_SOF;
                end
            end
            ST_SOF: begin
                if (mdio_in) begin
                    state_d = ST_OPC;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_HUNT;
                    armed_d = 1'b0;
                end
            end
            ST_OPC: begin
                sh_d = {sh_q[DATA_W-2:0], mdio_in};
                if (cnt_q == '0) begin
                    cnt_d = ONE;
                end else begin
                    cnt_d = '0;
                    if ({sh_q[0], mdio_in} == OPC_READ) begin
                        rd_d    = 1'b1;
                        state_d = ST_PHY;
                    end else if ({sh_q[0], mdio_in} == OPC_WRITE) begin
                        rd_d    = 1'b0;
                        state_d = ST_PHY;
                    end else begin
                        state_d = ST_HUNT;
                        armed_d = mdio_in;
                    end
                end
            end
            ST_PHY: begin
                sh_d = {sh_q[DATA_W-2:0], mdio_in};
                if (cnt_q == LAST_A) begin
                    cnt_d = '0;
                    if ({sh_q[ADDR_W-2:0], mdio_in} == phy_strap) begin
                        state_d = ST_REG;
                    end else begin
                        state_d = ST_HUNT;
                        armed_d = mdio_in;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_REG: begin
                sh_d = {sh_q[DATA_W-2:0], mdio_in};
                if (cnt_q == LAST_A) begin
                    cnt_d   = '0;
                    ra_d    = {sh_q[ADDR_W-2:0], mdio_in};
                    state_d = ST_TURN;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_TURN: begin
                if (cnt_q == '0) begin
                    cnt_d = ONE;
                end else begin
                    cnt_d   = '0;
                    state_d = rd_q ? ST_RDATA : ST_WDATA;
                end
            end
            ST_WDATA: begin
                sh_d = {sh_q[DATA_W-2:0], mdio_in};
                if (cnt_q == LAST_D) begin
                    cnt_d   = '0;
                    armed_d = 1'b1;
                    state_d = ST_HUNT;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_RDATA: begin
                if (cnt_q == LAST_D) begin
                    cnt_d   = '0;
                    armed_d = 1'b1;
                    state_d = ST_HUNT;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: begin
                state_d = ST_HUNT;
                armed_d = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            armed_q <= 1'b1;
            rd_q    <= 1'b0;
            sh_q    <= '0;
            ra_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
            rd_q    <= rd_d;
            sh_q    <= sh_d;
            ra_q    <= ra_d;
        end
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        tx_turn  = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        tx_drop  = 1'b0;
        unique case (state_q)
            ST_TURN: begin
                tx_turn = rd_q && (cnt_q == '0);
                tx_load = rd_q && (cnt_q != '0);
            end
            ST_WDATA: begin
                wr_en = (cnt_q == LAST_D);
            end
            ST_RDATA: begin
                tx_shift = (cnt_q != LAST_D);
                tx_drop  = (cnt_q == LAST_D);
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    assign state    = state_q;
    assign reg_addr = ra_q;
    assign wr_data  = {sh_q[DATA_W-2:0], mdio_in};

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    parameter int STATUS_IDX = 1,
    parameter int NOPRE_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NREGS = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] NOPRE_MASK = DATA_W'(1) << NOPRE_BIT;

    logic [NREGS-1:0][DATA_W-1:0] words;

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                q <= wr_data;
            end
        end
        if (g == STATUS_IDX) begin : g_status
            assign words[g] = q | NOPRE_MASK;
        end else begin : g_plain
            assign words[g] = q;
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/mdio_tx_path.sv
module mdio_tx_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              turn,
    input  logic              load,
    input  logic              shift,
    input  logic              drop,
    input  logic [DATA_W-1:0] load_data,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic              oe_q;
    logic              out_q;
    logic [DATA_W-2:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            out_q <= 1'b0;
            sr_q  <= '0;
        end else if (turn) begin
            oe_q  <= 1'b1;
            out_q <= 1'b0;
        end else if (load) begin
            out_q <= load_data[DATA_W-1];
            sr_q  <= load_data[DATA_W-2:0];
        end else if (shift) begin
            out_q <= sr_q[DATA_W-2];
            sr_q  <= {sr_q[DATA_W-3:0], 1'b0};
        end else if (drop) begin
            oe_q  <= 1'b0;
            out_q <= 1'b0;
        end
    end

    assign mdio_out = out_q;
    assign mdio_oe  = oe_q;

endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_target_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    parameter int STATUS_IDX = 1,
    parameter int NOPRE_BIT  = 6
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] phy_strap,
    output logic              mdio_out,
    output logic              mdio_oe
);

    mdio_state_e       fsm_state;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              tx_turn;
    logic              tx_load;
    logic              tx_shift;
    logic              tx_drop;

    mdio_frame_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .phy_strap(phy_strap),
        .state    (fsm_state),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .tx_turn  (tx_turn),
        .tx_load  (tx_load),
        .tx_shift (tx_shift),
        .tx_drop  (tx_drop)
    );

    mdio_regfile #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STATUS_IDX(STATUS_IDX),
        .NOPRE_BIT (NOPRE_BIT)
    ) u_regs (
        .clk    (mdc),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(reg_addr),
        .wr_data(wr_data),
        .rd_addr(reg_addr),
        .rd_data(rd_data)
    );

    mdio_tx_path #(
        .DATA_W(DATA_W)
    ) u_tx (
        .clk      (mdc),
        .rst_n    (rst_n),
        .turn     (tx_turn),
        .load     (tx_load),
        .shift    (tx_shift),
        .drop     (tx_drop),
        .load_data(rd_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk
    import mdio_target_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        oe,
    input logic        out,
    input mdio_state_e state,
    input logic        wr_en
);

    localparam int RUN_W = $clog2(DATA_W + 2) + 1;

    logic [RUN_W-1:0] oe_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_run <= '0;
        end else if (!oe) begin
            oe_run <= '0;
        end else if (oe_run != '1) begin
            oe_run <= oe_run + RUN_W'(1);
        end
    end

    AST_TURN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe) |-> !out); // R7
    AST_TURN_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe) |-> state == ST_TURN); // R7
    AST_RELEASE_HUNT: assert property (@(posedge clk) disable iff (!rst_n) $fell(oe) |-> state == ST_HUNT); // R8
    AST_DRIVE_SPAN: assert property (@(posedge clk) disable iff (!rst_n) oe |-> oe_run < RUN_W'(DATA_W + 1)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_HUNT && $past(state) == ST_HUNT) |-> !oe); // R1
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !oe); // R9

endmodule

bind mdio_target mdio_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk  (mdc),
    .rst_n(rst_n),
    .oe   (mdio_oe),
    .out  (mdio_out),
    .state(fsm_state),
    .wr_en(wr_en)
);

// File: tb/mdio_target_bench.sv
module mdio_target_bench;

    localparam logic [4:0] STRAP = 5'h13;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_item_t;

    logic mdc = 1'b0;
    logic rst_n = 1'b0;
    logic st_en = 1'b0;
    logic st_val = 1'b1;
    logic mdio_out;
    logic mdio_oe;
    logic line;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        oe_log [32];
    logic        ln_log [32];
    logic [15:0] model  [32];

    exp_item_t   exp_q[$];
    logic [15:0] obs_q[$];

    always #5 mdc = ~mdc;

    assign line = mdio_oe ? mdio_out : (st_en ? st_val : 1'b1);

    mdio_target u_mdio_target (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (line),
        .phy_strap(STRAP),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares words read off the line against the scoreboard
    always @(negedge mdc) begin
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            exp_item_t e;
            logic [15:0] o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            chk(o == e.val, e.tag, {16'h0, o}, {16'h0, e.val});
        end
    end

    function automatic logic [15:0] expect_of(input int ra);
        return model[ra] | ((ra == 1) ? 16'h0040 : 16'h0000);
    endfunction

    function automatic bit any_oe();
        bit hit;
        hit = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (oe_log[i]) hit = 1'b1;
        end
        return hit;
    endfunction

    task automatic slot(input logic en, input logic b, input int idx);
        @(negedge mdc);
        st_en  = en;
        st_val = b;
        #1;
        if (idx >= 0 && idx < 32) begin
            oe_log[idx] = mdio_oe;
            ln_log[idx] = line;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b0, 1'b1, -1);
    endtask

    task automatic frame(input int npre, input logic [1:0] op, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd);
        logic [31:0] bits;
        logic        rel;
        bits = {2'b01, op, pa, ra, 2'b10, wd};
        rel  = (op == 2'b10);
        for (int i = 0; i < npre; i++) slot(1'b1, 1'b1, -1);
        for (int k = 0; k < 32; k++) slot(!(rel && k >= 14), bits[31-k], k);
    endtask

    // driver for writes: updates the model and checks the line stays free
    task automatic do_write(input int npre, input int ra, input logic [15:0] wd);
        frame(npre, 2'b01, STRAP, 5'(ra), wd);
        model[ra] = wd;
        chk(!any_oe(), "R9 no drive in write", {31'h0, any_oe()}, 32'h0);
    endtask

    // driver for reads: pushes expected word, captures observed word
    task automatic do_read(input int npre, input int ra, input string tag);
        logic [15:0] w;
        exp_item_t   e;
        frame(npre, 2'b10, STRAP, 5'(ra), 16'h0);
        for (int i = 0; i < 16; i++) w[15-i] = ln_log[16+i];
        e.val = expect_of(ra);
        e.tag = tag;
        exp_q.push_back(e);
        obs_q.push_back(w);
        chk(oe_log[14] == 1'b0, "R7 first turnaround undriven", {31'h0, oe_log[14]}, 32'h0);
        chk(oe_log[15] == 1'b1 && ln_log[15] == 1'b0, "R7 second turnaround zero",
            {30'h0, oe_log[15], ln_log[15]}, 32'h2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 16'h0;
        repeat (3) @(negedge mdc);
        #1;
        chk(mdio_oe == 1'b0, "R1 reset enable", {31'h0, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R1 / R10: reset contents and status flag
        do_read(32, 0, "R1 reset register 0");
        do_read(32, 1, "R10 status at reset");

        // R2 / R6: writes with preamble, mirrored addresses
        do_write(32, 5, 16'hA5C3);
        do_write(32, 20, 16'h3C5A);
        do_read(32, 5, "R2 write then read");
        do_read(32, 20, "R6 msb-first address");

        // R3: no preamble after idle
        idle(3);
        do_write(0, 31, 16'h8001);
        idle(2);
        do_read(0, 31, "R3 preamble-free read");

        // R10: status bit survives writes
        do_write(32, 1, 16'h0000);
        do_read(32, 1, "R10 status after write 0");
        do_write(32, 1, 16'hFFBF);
        do_read(32, 1, "R10 status with other bits");

        // R4: unsupported opcodes
        idle(2);
        frame(32, 2'b00, 5'h1F, 5'h1F, 16'hFFFF);
        chk(!any_oe(), "R4 opcode 00 quiet", {31'h0, any_oe()}, 32'h0);
        idle(2);
        frame(32, 2'b11, 5'h1F, 5'h1F, 16'hFFFF);
        chk(!any_oe(), "R4 opcode 11 quiet", {31'h0, any_oe()}, 32'h0);
        idle(2);
        do_read(32, 31, "R4 register unchanged");

        // R5: PHY address mismatch
        idle(2);
        frame(32, 2'b01, STRAP ^ 5'h01, 5'h1F, 16'hFFFF);
        chk(!any_oe(), "R5 foreign write quiet", {31'h0, any_oe()}, 32'h0);
        idle(2);
        frame(32, 2'b10, STRAP ^ 5'h01, 5'h1F, 16'h0000);
        chk(!any_oe(), "R5 foreign read quiet", {31'h0, any_oe()}, 32'h0);
        idle(2);
        do_read(32, 31, "R5 register unchanged");

        // R11: back-to-back frames without gap or preamble
        idle(2);
        do_write(32, 7, 16'h7E57);
        do_write(0, 8, 16'h0810);
        do_read(0, 7, "R11 back-to-back first");
        do_read(0, 8, "R11 back-to-back second");

        // R8: line released in the bit time after the last data bit
        slot(1'b0, 1'b1, -1);
        chk(mdio_oe == 1'b0, "R8 release after data", {31'h0, mdio_oe}, 32'h0);

        idle(4);
        chk(exp_q.size() == 0, "R8 all reads observed", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule